// File: doc/BRIEF.md
# Wormhole Mesh Router with X-then-Y Routing

This block is one switching node of a two-dimensional mesh network-on-chip. It has five ports: four links to neighbouring nodes (north, east, south, west) and one port to the attached tile, which injects and ejects traffic. Every input has a small flit buffer. Packets travel as a head flit, optional body flits and a tail flit, or as a single flit that both opens and closes a packet. The head flit alone carries the destination. The router sends the packet along the X axis until its column matches its own, then along Y, and delivers it to the tile when both coordinates match.

An output that has accepted a head flit stays reserved for that input until the packet's tail has left, so packets never mix on a link. When several unreserved inputs want the same output, a round-robin arbiter picks one per cycle. Flow control is credit based in both directions, so there is no ready signal. An upstream sender may raise `in_valid` only while it holds a credit for that input. The router returns one credit on `in_credit` for each flit that leaves the input buffer. Toward each downstream neighbour, the router keeps a credit count that starts at the depth of the neighbour's buffer. It sends a flit only while that count is non-zero, and the neighbour returns credits on `out_credit`. A flit that has no credit waits in its input buffer.

The node's own coordinates come in on `my_x` and `my_y` and are held constant. Port index 0 is local, 1 north, 2 east, 3 south and 4 west. Y grows toward the south.

Top module: `mesh_router`

## Requirements
- R1: During and after reset, every `out_valid` and `in_credit` bit is 0. Each output's credit count starts at DS_DEPTH, so up to DS_DEPTH flits can leave an output before any credit comes back.
- R2: A flit is a 2-bit type in bits [FLIT_W-1:FLIT_W-2] above the payload. Bit 0 of the type marks the start of a packet and bit 1 marks the end: 00 is body, 01 is head, 10 is tail, 11 is single. In a head or single flit, payload bits [5:3] hold the destination X and bits [2:0] hold the destination Y. Flits pass through the router unchanged.
- R3: A head flit goes to east (2) if dest X > my_x, and to west (4) if dest X < my_x. If the X values are equal, it goes to south (3) if dest Y > my_y, and to north (1) if dest Y < my_y.
- R4: A head flit whose destination equals (my_x, my_y) leaves on the local port (0).
- R5: Body and tail flits follow the output chosen by their packet's head. Flits from one input to one output keep their order.
- R6: After an output sends a head flit, it sends only flits from the same input until that input's tail has been sent. A head or single flit appears on an output only outside a packet.
- R7: Each output sends at most one flit per cycle. Among the inputs competing for a free output, the one granted most recently gets the lowest priority. After reset, input 0 has the highest priority.
- R8: An output never has more than DS_DEPTH flits sent but not credited back. With no credit returned, it sends exactly DS_DEPTH flits and then stalls until a credit comes back.
- R9: Each flit that leaves an input buffer causes exactly one `in_credit` pulse on that input, one cycle after the flit is dequeued.
- R10: A flit on an uncontended path, with credits available, is sampled on rising edge k and appears on its output right after rising edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| my_x | input | COORD_W | Column of this node, held constant |
| my_y | input | COORD_W | Row of this node, held constant |
| in_valid | input | 5 | Flit present on each input port |
| in_flit | input | 5 x FLIT_W | Flit on each input port |
| in_credit | output | 5 | One-cycle credit returned to each upstream sender |
| out_valid | output | 5 | Flit present on each output port |
| out_flit | output | 5 x FLIT_W | Flit on each output port |
| out_credit | input | 5 | One-cycle credit returned by each downstream receiver |

## Verification
The assertions assume four things about the environment. Upstream senders never exceed BUF_DEPTH flits waiting in an input. Downstream receivers never return more credits than flits they have received. The coordinates stay fixed. Each input carries well-formed packets that open with a head or single flit and close with a tail. The bench meets these conditions by keeping its own credit counter per input and injecting only while that counter is positive. It returns output credits only from a per-output count of received flits. It builds every packet whole before queuing it on one input, and it never changes the coordinates after reset.

// File: rtl/router_pkg.sv
package router_pkg;

  // Port numbering used by the routing decision and by the outputs.
  localparam int NPORT = 5;

  typedef enum logic [2:0] {
    PORT_LOCAL = 3'd0,
    PORT_NORTH = 3'd1,
    PORT_EAST  = 3'd2,
    PORT_SOUTH = 3'd3,
    PORT_WEST  = 3'd4
  } port_e;

  // Type field: bit 0 opens a packet, bit 1 closes it.
  function automatic logic opens_pkt(input logic [1:0] ftype);
    return ftype[0];
  endfunction

  function automatic logic closes_pkt(input logic [1:0] ftype);
    return ftype[1];
  endfunction

endpackage

// File: rtl/router_in_fifo.sv
module router_in_fifo #(
  parameter int W     = 18,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         not_empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW:0]   FULL_CNT = (AW+1)'(DEPTH);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [AW:0]   cnt_q;
  logic          wr_ok, rd_ok;

  assign wr_ok     = wr_en && (cnt_q != FULL_CNT);
  assign rd_ok     = rd_en && (cnt_q != '0);
  assign not_empty = (cnt_q != '0);
  assign rd_data   = mem[rp_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (wr_ok) wp_q <= (wp_q == LAST_IDX) ? '0 : wp_q + 1'b1;
      if (rd_ok) rp_q <= (rp_q == LAST_IDX) ? '0 : rp_q + 1'b1;
      cnt_q <= cnt_q + (AW+1)'(wr_ok) - (AW+1)'(rd_ok);
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp_q] <= wr_data;
  end

endmodule

// File: rtl/router_route_unit.sv
module router_route_unit
  import router_pkg::*;
#(
  parameter int COORD_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               valid,
  input  logic [1:0]         ftype,
  input  logic [COORD_W-1:0] dest_x,
  input  logic [COORD_W-1:0] dest_y,
  input  logic [COORD_W-1:0] my_x,
  input  logic [COORD_W-1:0] my_y,
  input  logic               pop,
  output logic [NPORT-1:0]   req
);
  logic [NPORT-1:0] fresh, held_q, route_now;

  // X first, then Y, then eject.
  always_comb begin
    fresh = '0;
    if (dest_x > my_x)      fresh[PORT_EAST]  = 1'b1;
    else if (dest_x < my_x) fresh[PORT_WEST]  = 1'b1;
    else if (dest_y > my_y) fresh[PORT_SOUTH] = 1'b1;
    else if (dest_y < my_y) fresh[PORT_NORTH] = 1'b1;
    else                    fresh[PORT_LOCAL] = 1'b1;
  end

  assign route_now = opens_pkt(ftype) ? fresh : held_q;
  assign req       = valid ? route_now : '0;

  // Remember the head's choice for the body and tail that follow.
  always_ff @(posedge clk) begin
    if (!rst_n) held_q <= '0;
    else if (pop && opens_pkt(ftype) && !closes_pkt(ftype)) held_q <= fresh;
  end

endmodule

// File: rtl/router_rr_arb.sv
module router_rr_arb #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic         advance,
  output logic [N-1:0] grant
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;
  localparam logic [IW-1:0] START = IW'(N - 1);

  logic [IW-1:0] last_q;

  // Search starts just after the last winner.
  always_comb begin
    grant = '0;
    for (int k = 1; k <= N; k++) begin
      int idx;
      idx = int'(last_q) + k;
      if (idx >= N) idx = idx - N;
      if (grant == '0 && req[idx]) grant[idx] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= START;
    else if (advance) begin
      for (int j = 0; j < N; j++)
        if (grant[j]) last_q <= IW'(j);
    end
  end

endmodule

// File: rtl/router_out_port.sv
module router_out_port
  import router_pkg::*;
#(
  parameter int NIN      = 5,
  parameter int FLIT_W   = 18,
  parameter int DS_DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NIN-1:0]               req,
  input  logic [NIN-1:0][FLIT_W-1:0]   flits,
  input  logic                         credit_ret,
  output logic [NIN-1:0]               send_vec,
  output logic                         out_valid,
  output logic [FLIT_W-1:0]            out_flit
);
  localparam int CNT_W = $clog2(DS_DEPTH + 1);
  localparam logic [CNT_W-1:0] CRD_INIT = CNT_W'(DS_DEPTH);

  logic                 locked_q;
  logic [NIN-1:0]       owner_q;
  logic [CNT_W-1:0]     crd_q;
  logic [NIN-1:0]       arb_req, arb_gnt, sel;
  logic                 can_send, send;
  logic [FLIT_W-1:0]    xbar;
  logic [1:0]           ftype;

  assign arb_req = locked_q ? '0 : req;

  router_rr_arb #(.N(NIN)) arb_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (arb_req),
    .advance (send && !locked_q),
    .grant   (arb_gnt)
  );

  assign sel      = locked_q ? (owner_q & req) : arb_gnt;
  assign can_send = (crd_q != '0);
  assign send_vec = can_send ? sel : '0;
  assign send     = |send_vec;

  // Crossbar column: one-hot select of the granted input.
  always_comb begin
    xbar = '0;
    for (int i = 0; i < NIN; i++)
      if (send_vec[i]) xbar = xbar | flits[i];
  end

  assign ftype = xbar[FLIT_W-1:FLIT_W-2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked_q  <= 1'b0;
      owner_q   <= '0;
      crd_q     <= CRD_INIT;
      out_valid <= 1'b0;
      out_flit  <= '0;
    end else begin
      crd_q     <= crd_q + CNT_W'(credit_ret) - CNT_W'(send);
      out_valid <= send;
      if (send) begin
        out_flit <= xbar;
        if (closes_pkt(ftype)) begin
          locked_q <= 1'b0;
        end else if (opens_pkt(ftype)) begin
          locked_q <= 1'b1;
          owner_q  <= send_vec;
        end
      end
    end
  end

endmodule

// File: rtl/mesh_router.sv
module mesh_router
  import router_pkg::*;
#(
  parameter int PAYLOAD_W = 16,
  parameter int COORD_W   = 3,
  parameter int BUF_DEPTH = 4,
  parameter int DS_DEPTH  = 4,
  localparam int FLIT_W   = PAYLOAD_W + 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [COORD_W-1:0]             my_x,
  input  logic [COORD_W-1:0]             my_y,
  input  logic [NPORT-1:0]               in_valid,
  input  logic [NPORT-1:0][FLIT_W-1:0]   in_flit,
  output logic [NPORT-1:0]               in_credit,
  output logic [NPORT-1:0]               out_valid,
  output logic [NPORT-1:0][FLIT_W-1:0]   out_flit,
  input  logic [NPORT-1:0]               out_credit
);
  logic [NPORT-1:0][FLIT_W-1:0] head;
  logic [NPORT-1:0]             has_flit, pop;
  logic [NPORT-1:0][NPORT-1:0]  req_in;   // [input][output]
  logic [NPORT-1:0][NPORT-1:0]  req_out;  // [output][input]
  logic [NPORT-1:0][NPORT-1:0]  snd;      // [output][input]

  for (genvar i = 0; i < NPORT; i++) begin : g_in
    router_in_fifo #(.W(FLIT_W), .DEPTH(BUF_DEPTH)) fifo_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (in_valid[i]),
      .wr_data   (in_flit[i]),
      .rd_en     (pop[i]),
      .rd_data   (head[i]),
      .not_empty (has_flit[i])
    );

    router_route_unit #(.COORD_W(COORD_W)) route_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .valid  (has_flit[i]),
      .ftype  (head[i][FLIT_W-1:FLIT_W-2]),
      .dest_x (head[i][2*COORD_W-1:COORD_W]),
      .dest_y (head[i][COORD_W-1:0]),
      .my_x   (my_x),
      .my_y   (my_y),
      .pop    (pop[i]),
      .req    (req_in[i])
    );
  end

  always_comb begin
    for (int o = 0; o < NPORT; o++)
      for (int i = 0; i < NPORT; i++)
        req_out[o][i] = req_in[i][o];
  end

  for (genvar o = 0; o < NPORT; o++) begin : g_out
    router_out_port #(.NIN(NPORT), .FLIT_W(FLIT_W), .DS_DEPTH(DS_DEPTH)) port_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .req        (req_out[o]),
      .flits      (head),
      .credit_ret (out_credit[o]),
      .send_vec   (snd[o]),
      .out_valid  (out_valid[o]),
      .out_flit   (out_flit[o])
    );
  end

  // An input is dequeued when any output takes its head flit.
  always_comb begin
    pop = '0;
    for (int o = 0; o < NPORT; o++) pop = pop | snd[o];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) in_credit <= '0;
    else        in_credit <= pop;
  end

endmodule

// File: rtl/router_checker.sv
module router_checker
  import router_pkg::*;
#(
  parameter int PAYLOAD_W = 16,
  parameter int COORD_W   = 3,
  parameter int BUF_DEPTH = 4,
  parameter int DS_DEPTH  = 4,
  localparam int FLIT_W   = PAYLOAD_W + 2
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [COORD_W-1:0]           my_x,
  input logic [COORD_W-1:0]           my_y,
  input logic [NPORT-1:0]             in_valid,
  input logic [NPORT-1:0][FLIT_W-1:0] in_flit,
  input logic [NPORT-1:0]             in_credit,
  input logic [NPORT-1:0]             out_valid,
  input logic [NPORT-1:0][FLIT_W-1:0] out_flit,
  input logic [NPORT-1:0]             out_credit
);
  logic chk_unused;
  assign chk_unused = ^{in_flit, out_flit};

  for (genvar i = 0; i < NPORT; i++) begin : g_inchk
    int occ_q;
    always_ff @(posedge clk) begin
      if (!rst_n) occ_q <= 0;
      else        occ_q <= occ_q + int'(in_valid[i]) - int'(in_credit[i]);
    end

    AST_CREDIT_BACKED: assert property (@(posedge clk) disable iff (!rst_n)
      in_credit[i] |-> occ_q > 0); // R9
    AST_IN_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
      occ_q <= BUF_DEPTH); // R9
  end

  for (genvar o = 0; o < NPORT; o++) begin : g_outchk
    int   os_q;
    logic in_pkt_q;
    logic dir_ok;
    logic [COORD_W-1:0] dx, dy;
    logic xeq;

    assign dx  = out_flit[o][2*COORD_W-1:COORD_W];
    assign dy  = out_flit[o][COORD_W-1:0];
    assign xeq = (dx == my_x);

    always_comb begin
      case (o)
        0:       dir_ok = xeq && (dy == my_y);
        1:       dir_ok = xeq && (dy < my_y);
        2:       dir_ok = (dx > my_x);
        3:       dir_ok = xeq && (dy > my_y);
        default: dir_ok = (dx < my_x);
      endcase
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        os_q     <= 0;
        in_pkt_q <= 1'b0;
      end else begin
        os_q <= os_q + int'(out_valid[o]) - int'(out_credit[o]);
        if (out_valid[o]) in_pkt_q <= !out_flit[o][FLIT_W-1];
      end
    end

    AST_CREDIT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      os_q <= DS_DEPTH); // R8
    AST_NO_INTERLEAVE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[o] |-> (out_flit[o][FLIT_W-2] == !in_pkt_q)); // R6

    if (o == 0) begin : g_local
      AST_LOCAL_EJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid[o] && out_flit[o][FLIT_W-2]) |-> dir_ok); // R4
    end else begin : g_link
      AST_ROUTE_XY: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid[o] && out_flit[o][FLIT_W-2]) |-> dir_ok); // R3
    end
  end

endmodule

bind mesh_router router_checker #(
  .PAYLOAD_W (PAYLOAD_W),
  .COORD_W   (COORD_W),
  .BUF_DEPTH (BUF_DEPTH),
  .DS_DEPTH  (DS_DEPTH)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .my_x       (my_x),
  .my_y       (my_y),
  .in_valid   (in_valid),
  .in_flit    (in_flit),
  .in_credit  (in_credit),
  .out_valid  (out_valid),
  .out_flit   (out_flit),
  .out_credit (out_credit)
);

// File: tb/mesh_router_tb_top.sv
module mesh_router_tb_top;
  localparam int NP  = 5;
  localparam int FW  = 18;
  localparam int DEP = 4;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic [2:0]           my_x = 3'd3, my_y = 3'd4;
  logic [NP-1:0]        in_valid = '0;
  logic [NP-1:0][FW-1:0] in_flit = '0;
  logic [NP-1:0]        in_credit;
  logic [NP-1:0]        out_valid;
  logic [NP-1:0][FW-1:0] out_flit;
  logic [NP-1:0]        out_credit = '0;

  always #2 clk = ~clk;

  mesh_router dut_i (
    .clk(clk), .rst_n(rst_n), .my_x(my_x), .my_y(my_y),
    .in_valid(in_valid), .in_flit(in_flit), .in_credit(in_credit),
    .out_valid(out_valid), .out_flit(out_flit), .out_credit(out_credit)
  );

  int tests = 0, fails = 0;
  int in_cr [NP];
  int pend [NP];
  int nout [NP];
  int cur_src [NP];
  bit inpkt [NP];
  bit hold [NP];
  bit gap_en = 0;
  logic [FW-1:0] pq [NP][$];
  logic [FW-1:0] expq [NP*NP][$];
  int rr_log [$];

  task automatic chk(input bit ok, input string req, input logic [FW-1:0] act, input logic [FW-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int ref_port(int dx, int dy, int mx, int my);
    if (dx > mx) return 2;
    if (dx < mx) return 4;
    if (dy > my) return 3;
    if (dy < my) return 1;
    return 0;
  endfunction

  task automatic add_pkt(input int src, input int dx, input int dy, input int len, input int id);
    int o;
    o = ref_port(dx, dy, int'(my_x), int'(my_y));
    for (int k = 0; k < len; k++) begin
      logic [1:0] t;
      logic [15:0] pl;
      logic [FW-1:0] f;
      t = (len == 1) ? 2'b11 : (k == 0) ? 2'b01 : (k == len-1) ? 2'b10 : 2'b00;
      if (k == 0) pl = {7'(id), 3'(src), 3'(dx), 3'(dy)};
      else        pl = {7'(id), 3'(src), 6'(k)};
      f = {t, pl};
      pq[src].push_back(f);
      expq[o*NP+src].push_back(f);
    end
  endtask

  function automatic bit busy();
    for (int p = 0; p < NP; p++) if (pq[p].size() != 0 || inpkt[p]) return 1;
    for (int q = 0; q < NP*NP; q++) if (expq[q].size() != 0) return 1;
    return 0;
  endfunction

  task automatic wait_idle(input int limit);
    for (int c = 0; c < limit && busy(); c++) @(negedge clk);
    repeat (10) @(negedge clk);
  endtask

  // Input driver, just after the falling edge.
  always @(negedge clk) begin
    #1;
    in_valid = '0;
    if (rst_n) begin
      for (int p = 0; p < NP; p++) begin
        if (pq[p].size() > 0 && in_cr[p] > 0 && (!gap_en || $urandom_range(0, 3) != 0)) begin
          in_flit[p]  = pq[p].pop_front();
          in_valid[p] = 1'b1;
          in_cr[p]--;
        end
      end
    end
  end

  // Output monitor, scoreboard and downstream credit return.
  always @(negedge clk) begin
    if (rst_n) begin
      for (int p = 0; p < NP; p++) if (in_credit[p]) in_cr[p]++;
      for (int o = 0; o < NP; o++) begin
        if (out_valid[o]) begin
          logic [FW-1:0] f, e;
          int idx;
          f = out_flit[o];
          if (!inpkt[o]) begin
            chk(f[FW-2] == 1'b1, "R6 packet must open with head", f, '0);
            cur_src[o] = int'(f[8:6]);
          end else begin
            chk(f[FW-2] == 1'b0, "R6 head inside open packet", f, '0);
          end
          idx = o*NP + cur_src[o];
          if (expq[idx].size() == 0) begin
            chk(1'b0, "R3 flit on unexpected output", f, '0);
          end else begin
            e = expq[idx].pop_front();
            chk(f == e, "R5 flit content/order (R2 format)", f, e);
          end
          inpkt[o] = !f[FW-1];
          if (o == 0) rr_log.push_back(int'(f[8:6]));
          nout[o]++;
          pend[o]++;
        end
        out_credit[o] = 1'b0;
        if (pend[o] > 0 && !hold[o] && $urandom_range(0, 1) == 1) begin
          out_credit[o] = 1'b1;
          pend[o]--;
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int base;
    void'($urandom(32'd1234));
    for (int p = 0; p < NP; p++) begin
      in_cr[p] = DEP; pend[p] = 0; nout[p] = 0; inpkt[p] = 0; hold[p] = 0; cur_src[p] = 0;
    end
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(out_valid == '0, "R1 out_valid in reset", FW'(out_valid), '0);
    chk(in_credit == '0, "R1 in_credit in reset", FW'(in_credit), '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == '0 && in_credit == '0, "R1 idle after reset", FW'({out_valid, in_credit}), '0);

    // R10 latency: local -> east, single flit.
    #2; add_pkt(0, 6, 4, 1, 1);
    @(negedge clk);
    @(negedge clk);
    chk(out_valid[2] == 1'b0, "R10 not yet after first edge", FW'(out_valid[2]), '0);
    @(negedge clk);
    chk(out_valid[2] == 1'b1, "R10 out after second edge", FW'(out_valid[2]), 1);
    wait_idle(200);

    // R8 / R1: credits withheld on east.
    hold[2] = 1; base = nout[2];
    for (int k = 0; k < 6; k++) add_pkt(0, 7, 1, 1, 10 + k);
    repeat (20) @(negedge clk);
    chk(nout[2] - base == DEP, "R8 R1 stall at downstream depth", FW'(nout[2] - base), FW'(DEP));
    hold[2] = 0;
    wait_idle(300);
    chk(nout[2] - base == 6, "R8 resume after credits", FW'(nout[2] - base), 6);

    // R7 round robin: north and west both to local.
    rr_log.delete();
    add_pkt(1, 3, 4, 1, 20); add_pkt(1, 3, 4, 1, 21);
    add_pkt(4, 3, 4, 1, 22); add_pkt(4, 3, 4, 1, 23);
    wait_idle(300);
    chk(rr_log.size() == 4 && rr_log[0] == 1 && rr_log[1] == 4 && rr_log[2] == 1 && rr_log[3] == 4,
        "R7 alternating grants", FW'(rr_log.size() == 4 ? {rr_log[0], rr_log[1], rr_log[2], rr_log[3]} : 0), FW'(32'h1414));
    chk(nout[0] == 4, "R4 local ejection count", FW'(nout[0]), 4);

    // R6 wormhole lock: two 3-flit packets north and east to local.
    rr_log.delete();
    add_pkt(1, 3, 4, 3, 30);
    add_pkt(2, 3, 4, 3, 31);
    wait_idle(300);
    chk(rr_log.size() == 6 && rr_log[0] == 1 && rr_log[1] == 1 && rr_log[2] == 1 &&
        rr_log[3] == 2 && rr_log[4] == 2 && rr_log[5] == 2,
        "R6 packets contiguous", FW'(rr_log.size()), 6);

    // Constrained random traffic.
    gap_en = 1;
    for (int n = 0; n < 200; n++)
      add_pkt($urandom_range(0, 4), $urandom_range(0, 7), $urandom_range(0, 7),
              $urandom_range(1, 4), 40 + n);
    wait_idle(8000);
    chk(!busy(), "R3 R5 all random traffic delivered", FW'(busy()), '0);
    for (int p = 0; p < NP; p++)
      chk(in_cr[p] == DEP, "R9 every input credit returned", FW'(in_cr[p]), FW'(DEP));

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule